// File: doc/BRIEF.md
# Per-Source Configurable Interrupt Controller

This block gathers a parameterised set of interrupt request lines (32 by default) and turns them into two processor interrupt lines: a normal one and a fast one. Every request line first passes through a multi-flop synchronizer, so the lines may be driven from any clock domain. Each source is set up on its own. It can be sensitive to a level or to an edge, and its polarity can be active-high/rising or active-low/falling. A latched raw status word holds the state of each source. A per-source enable word gates the raw word to give a masked status word. A per-source routing bit then sends each masked bit to one output or the other.

Software reaches the block through a simple 32-bit register bus. It has a single-cycle write strobe and a read port that decodes the address combinationally. An edge event is cleared by writing a one to its bit in the raw status register. The enable, polarity, sensitivity and routing words all clear to zero on reset. In that state every source is blocked, active-low and level-sensitive.

Top module: `irq_hub`

## Requirements
- R1: After reset, the enable (0x00), polarity (0x0C), sensitivity (0x10) and routing (0x14) registers read zero, the masked status reads zero, and both interrupt outputs are low.
- R2: Registers are decoded at byte offsets 0x00 enable, 0x04 raw status, 0x08 masked status, 0x0C polarity, 0x10 sensitivity and 0x14 routing, with bit n belonging to source n. The enable, polarity, sensitivity and routing registers read back the last value written. Writes to 0x08 have no effect. Any other offset reads zero.
- R3: A change on a request input reaches the raw status on the third rising clock edge after it is applied, and not earlier.
- R4: With a sensitivity bit of 0 (level), the raw bit is 1 while the synchronized input equals its polarity bit (1 = active-high, 0 = active-low), and is 0 otherwise.
- R5: With a sensitivity bit of 1 (edge), a transition towards the active polarity (rising for polarity 1, falling for polarity 0) sets the raw bit. The bit then stays set after the input returns. A transition in the other direction sets nothing.
- R6: Writing 1 to a bit of the raw register (0x04) clears a latched edge event for that source. Writing 0 leaves the bit unchanged.
- R7: For a level-sensitive source whose input is still asserted, writing 1 to its raw bit leaves the bit set.
- R8: If a clearing write to the raw register and a new edge on the same source fall in the same cycle, the raw bit remains set.
- R9: The masked status equals raw status AND enable. Changing the enable does not alter the raw status.
- R10: The fast output is high when any masked bit with routing bit 1 is set. The normal output is high when any masked bit with routing bit 0 is set. Both outputs are registered and follow the masked status one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_src_i | input | NUM_SRC | Asynchronous interrupt request lines |
| bus_wr_i | input | 1 | Single-cycle register write strobe |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for the addressed register (combinational) |
| norm_irq_o | output | 1 | Normal interrupt output |
| fast_irq_o | output | 1 | Fast interrupt output |

## Verification
The assertions take for granted that the bus write strobe lasts exactly one cycle and that address and data are valid while it is high. They also assume that reset is applied synchronously before any request line is sampled. The edge properties assume an input transition stays stable long enough to pass through the synchronizer as a single step. The stimulus therefore holds every request level for at least four clocks. It changes inputs and bus signals only a short time after a rising edge, and it places the clearing write for the collision case on exactly the edge where the synchronized edge is detected.

// File: rtl/irq_hub_pkg.sv
`timescale 1ns/1ps
package irq_hub_pkg;

   // Byte offsets of the software-visible registers
   localparam int unsigned OFS_ENABLE = 32'h00;
   localparam int unsigned OFS_RAW    = 32'h04;
   localparam int unsigned OFS_MASKED = 32'h08;
   localparam int unsigned OFS_POL    = 32'h0C;
   localparam int unsigned OFS_SENSE  = 32'h10;
   localparam int unsigned OFS_ROUTE  = 32'h14;

   // Smallest address width that reaches the highest offset
   localparam int unsigned MIN_ADDR_W = 5;

   typedef enum logic [2:0] {
      SEL_ENABLE,
      SEL_RAW,
      SEL_MASKED,
      SEL_POL,
      SEL_SENSE,
      SEL_ROUTE,
      SEL_NONE
   } reg_sel_e;

endpackage

// File: rtl/irq_hub_sync.sv
`timescale 1ns/1ps
module irq_hub_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("irq_hub_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/irq_hub_src.sv
`timescale 1ns/1ps
module irq_hub_src (
   input  logic clk,
   input  logic rst,
   input  logic sync_i,    // synchronized request
   input  logic hi_i,      // 1: active-high / rising
   input  logic edge_i,    // 1: edge, 0: level
   input  logic ack_i,     // write-one-to-clear strobe
   output logic raw_o
);

   logic prev_q;
   logic raw_q;
   logic act_now;
   logic act_old;
   logic hit;

   // Polarity-adjusted view of the current and the previous sample
   assign act_now = hi_i ? sync_i : ~sync_i;
   assign act_old = hi_i ? prev_q : ~prev_q;
   assign hit     = act_now & ~act_old;

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q <= 1'b0;
         raw_q  <= 1'b0;
      end else begin
         prev_q <= sync_i;
         if (edge_i) begin
            // a fresh event overrides a simultaneous clear
            raw_q <= hit | (raw_q & ~ack_i);
         end else begin
            raw_q <= act_now;
         end
      end
   end

   assign raw_o = raw_q;

   AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (edge_i && raw_q && !ack_i) |=> raw_q);                        // R5

   AST_EDGE_WINS: assert property (@(posedge clk) disable iff (rst)
      (edge_i && hit) |=> raw_q);                                    // R8

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (edge_i && ack_i && !hit) |=> !raw_q);                         // R6

   AST_LEVEL_ACK_IGNORED: assert property (@(posedge clk) disable iff (rst)
      (!edge_i && act_now && ack_i) |=> raw_q);                      // R7

endmodule

// File: rtl/irq_hub_regs.sv
`timescale 1ns/1ps
module irq_hub_regs
   import irq_hub_pkg::*;
#(
   parameter int unsigned NUM_SRC = 32,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 5
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               wr_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [DATA_W-1:0]  wdata_i,
   input  logic [NUM_SRC-1:0] raw_i,
   input  logic [NUM_SRC-1:0] masked_i,
   output logic [NUM_SRC-1:0] en_o,
   output logic [NUM_SRC-1:0] hi_o,
   output logic [NUM_SRC-1:0] edge_o,
   output logic [NUM_SRC-1:0] fast_o,
   output logic [NUM_SRC-1:0] ack_o,
   output logic [DATA_W-1:0]  rdata_o
);

   generate
      if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_width
         $error("irq_hub_regs: NUM_SRC must lie in 1..DATA_W");
      end
      if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
         $error("irq_hub_regs: ADDR_W too small for the register map");
      end
   endgenerate

   reg_sel_e           sel;
   logic [NUM_SRC-1:0] wbits;
   logic [NUM_SRC-1:0] en_q;
   logic [NUM_SRC-1:0] hi_q;
   logic [NUM_SRC-1:0] edge_q;
   logic [NUM_SRC-1:0] fast_q;

   always_comb begin
      sel = SEL_NONE;
      if      (addr_i == ADDR_W'(OFS_ENABLE)) sel = SEL_ENABLE;
      else if (addr_i == ADDR_W'(OFS_RAW))    sel = SEL_RAW;
      else if (addr_i == ADDR_W'(OFS_MASKED)) sel = SEL_MASKED;
      else if (addr_i == ADDR_W'(OFS_POL))    sel = SEL_POL;
      else if (addr_i == ADDR_W'(OFS_SENSE))  sel = SEL_SENSE;
      else if (addr_i == ADDR_W'(OFS_ROUTE))  sel = SEL_ROUTE;
   end

   assign wbits = wdata_i[NUM_SRC-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         en_q   <= '0;
         hi_q   <= '0;
         edge_q <= '0;
         fast_q <= '0;
      end else if (wr_i) begin
         if (sel == SEL_ENABLE) en_q   <= wbits;
         if (sel == SEL_POL)    hi_q   <= wbits;
         if (sel == SEL_SENSE)  edge_q <= wbits;
         if (sel == SEL_ROUTE)  fast_q <= wbits;
      end
   end

   assign ack_o  = (wr_i && sel == SEL_RAW) ? wbits : '0;
   assign en_o   = en_q;
   assign hi_o   = hi_q;
   assign edge_o = edge_q;
   assign fast_o = fast_q;

   always_comb begin
      rdata_o = '0;
      case (sel)
         SEL_ENABLE: rdata_o[NUM_SRC-1:0] = en_q;
         SEL_RAW:    rdata_o[NUM_SRC-1:0] = raw_i;
         SEL_MASKED: rdata_o[NUM_SRC-1:0] = masked_i;
         SEL_POL:    rdata_o[NUM_SRC-1:0] = hi_q;
         SEL_SENSE:  rdata_o[NUM_SRC-1:0] = edge_q;
         SEL_ROUTE:  rdata_o[NUM_SRC-1:0] = fast_q;
         default:    rdata_o = '0;
      endcase
   end

   AST_MASKED_RO: assert property (@(posedge clk) disable iff (rst)
      (wr_i && sel == SEL_MASKED)
      |=> ($stable(en_q) && $stable(hi_q) && $stable(edge_q) && $stable(fast_q))); // R2

   AST_ACK_ONLY_RAW: assert property (@(posedge clk) disable iff (rst)
      (sel != SEL_RAW) |-> (ack_o == '0));                           // R6

endmodule

// File: rtl/irq_hub.sv
`timescale 1ns/1ps
module irq_hub #(
   parameter int unsigned NUM_SRC     = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_SRC-1:0] irq_src_i,
   input  logic               bus_wr_i,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic [DATA_W-1:0]  bus_wdata_i,
   output logic [DATA_W-1:0]  bus_rdata_o,
   output logic               norm_irq_o,
   output logic               fast_irq_o
);

   logic [NUM_SRC-1:0] sync_s;
   logic [NUM_SRC-1:0] raw_s;
   logic [NUM_SRC-1:0] masked_s;
   logic [NUM_SRC-1:0] en_s;
   logic [NUM_SRC-1:0] hi_s;
   logic [NUM_SRC-1:0] edge_s;
   logic [NUM_SRC-1:0] fast_s;
   logic [NUM_SRC-1:0] ack_s;
   logic               norm_q;
   logic               fast_q;

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
         irq_hub_sync #(
            .STAGES (SYNC_STAGES)
         ) u_sync (
            .clk (clk),
            .rst (rst),
            .d_i (irq_src_i[i]),
            .q_o (sync_s[i])
         );

         irq_hub_src u_src (
            .clk    (clk),
            .rst    (rst),
            .sync_i (sync_s[i]),
            .hi_i   (hi_s[i]),
            .edge_i (edge_s[i]),
            .ack_i  (ack_s[i]),
            .raw_o  (raw_s[i])
         );
      end
   endgenerate

   assign masked_s = raw_s & en_s;

   irq_hub_regs #(
      .NUM_SRC (NUM_SRC),
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W)
   ) u_regs (
      .clk      (clk),
      .rst      (rst),
      .wr_i     (bus_wr_i),
      .addr_i   (bus_addr_i),
      .wdata_i  (bus_wdata_i),
      .raw_i    (raw_s),
      .masked_i (masked_s),
      .en_o     (en_s),
      .hi_o     (hi_s),
      .edge_o   (edge_s),
      .fast_o   (fast_s),
      .ack_o    (ack_s),
      .rdata_o  (bus_rdata_o)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         norm_q <= 1'b0;
         fast_q <= 1'b0;
      end else begin
         norm_q <= |(masked_s & ~fast_s);
         fast_q <= |(masked_s &  fast_s);
      end
   end

   assign norm_irq_o = norm_q;
   assign fast_irq_o = fast_q;

   AST_FAST_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      (|(masked_s & fast_s)) |=> fast_irq_o);                        // R10

   AST_NORM_QUIET: assert property (@(posedge clk) disable iff (rst)
      (!(|(masked_s & ~fast_s))) |=> !norm_irq_o);                   // R10

   AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
      (en_s == '0) |=> (!norm_irq_o && !fast_irq_o));                // R9

endmodule

// File: tb/irq_hub_bench.sv
`timescale 1ns/1ps
module irq_hub_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] src = '0;
   logic        wr = 1'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        nirq;
   logic        firq;

   irq_hub u_irq_hub (
      .clk         (clk),
      .rst         (rst),
      .irq_src_i   (src),
      .bus_wr_i    (wr),
      .bus_addr_i  (addr),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .norm_irq_o  (nirq),
      .fast_irq_o  (firq)
   );

   always #4 clk = ~clk;   // 125 MHz

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit [31:0] m_s1, m_s2, m_prev, m_raw, m_en, m_pol, m_typ, m_fast;
   bit        m_n, m_f;

   function automatic bit [31:0] m_read(input bit [4:0] a);
      case (a)
         5'h00:   return m_en;
         5'h04:   return m_raw;
         5'h08:   return m_raw & m_en;
         5'h0C:   return m_pol;
         5'h10:   return m_typ;
         5'h14:   return m_fast;
         default: return 32'h0;
      endcase
   endfunction

   always @(posedge clk) begin : model
      bit [31:0] act, actp, hit, clr, rawn, msk;
      if (rst) begin
         m_s1 = 0; m_s2 = 0; m_prev = 0; m_raw = 0;
         m_en = 0; m_pol = 0; m_typ = 0; m_fast = 0;
         m_n = 0; m_f = 0;
      end else begin
         act  = ~(m_s2 ^ m_pol);
         actp = ~(m_prev ^ m_pol);
         hit  = act & ~actp;
         clr  = (wr && addr == 5'h04) ? wdata : 32'h0;
         for (int i = 0; i < 32; i++) begin
            if (m_typ[i]) rawn[i] = hit[i] | (m_raw[i] & ~clr[i]);
            else          rawn[i] = act[i];
         end
         msk  = m_raw & m_en;
         m_n  = (msk & ~m_fast) != 0;
         m_f  = (msk &  m_fast) != 0;
         if (wr) begin
            case (addr)
               5'h00: m_en   = wdata;
               5'h0C: m_pol  = wdata;
               5'h10: m_typ  = wdata;
               5'h14: m_fast = wdata;
               default: ;
            endcase
         end
         m_prev = m_s2;
         m_s2   = m_s1;
         m_s1   = src;
         m_raw  = rawn;
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (!rst && !done) begin
         chk("R10 normal output vs model", {31'b0, nirq}, {31'b0, m_n});
         chk("R10 fast output vs model", {31'b0, firq}, {31'b0, m_f});
         chk("R2 read data vs model", rdata, m_read(addr));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic wreg(input logic [4:0] a, input logic [31:0] d);
      wr = 1'b1; addr = a; wdata = d;
      tick();
      wr = 1'b0; wdata = '0;
   endtask

   task automatic rchk(input string tag, input logic [4:0] a, input logic [31:0] exp);
      addr = a;
      @(negedge clk);
      chk(tag, rdata, exp);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stim
      ticks(3);
      rst = 1'b0;
      // R1 reset state
      rchk("R1 enable after reset", 5'h00, 32'h0);
      rchk("R1 polarity after reset", 5'h0C, 32'h0);
      rchk("R1 sensitivity after reset", 5'h10, 32'h0);
      rchk("R1 routing after reset", 5'h14, 32'h0);
      rchk("R1 masked after reset", 5'h08, 32'h0);
      chk("R1 normal output after reset", {31'b0, nirq}, 32'h0);
      chk("R1 fast output after reset", {31'b0, firq}, 32'h0);
      // R2 unmapped and read-only
      tick();
      rchk("R2 unmapped offset reads zero", 5'h18, 32'h0);
      tick();
      wreg(5'h08, 32'hFFFF_FFFF);
      rchk("R2 write to masked ignored (enable)", 5'h00, 32'h0);
      tick();
      rchk("R2 write to masked ignored (masked)", 5'h08, 32'h0);
      tick();
      // R4 active-low level, R9 masking, R10 normal routing
      wreg(5'h00, 32'h1);
      ticks(2);
      rchk("R4 active-low inputs at 0 read raw set", 5'h04, 32'hFFFF_FFFF);
      tick();
      rchk("R9 masked equals raw and enable", 5'h08, 32'h1);
      tick();
      rchk("R2 enable read back", 5'h00, 32'h1);
      chk("R10 normal output asserted", {31'b0, nirq}, 32'h1);
      chk("R10 fast output idle", {31'b0, firq}, 32'h0);
      tick();
      // R10 routing to the fast output, registered
      wreg(5'h14, 32'h1);
      chk("R10 normal output one cycle late", {31'b0, nirq}, 32'h1);
      tick();
      chk("R10 fast output after routing", {31'b0, firq}, 32'h1);
      chk("R10 normal output after routing", {31'b0, nirq}, 32'h0);
      // R4 active-high level, R3 latency
      wreg(5'h0C, 32'hFFFF_FFFF);
      ticks(2);
      rchk("R4 active-high inputs at 0 read raw clear", 5'h04, 32'h0);
      tick();
      src = 32'h8;
      ticks(2);
      rchk("R3 raw not set before third edge", 5'h04, 32'h0);
      tick();
      rchk("R3 raw set on third edge", 5'h04, 32'h8);
      tick();
      // R7 level source ignores clear while asserted
      wreg(5'h04, 32'h8);
      rchk("R7 level clear ignored", 5'h04, 32'h8);
      tick();
      // R5 rising edge latch
      wreg(5'h10, 32'h20);
      src = 32'h28;
      ticks(4);
      rchk("R5 rising edge latched", 5'h04, 32'h28);
      tick();
      src = 32'h08;
      ticks(4);
      rchk("R5 edge event held after input drops", 5'h04, 32'h28);
      tick();
      // R6 write-one-to-clear
      wreg(5'h04, 32'h0);
      rchk("R6 writing zero keeps edge bit", 5'h04, 32'h28);
      tick();
      wreg(5'h04, 32'h20);
      rchk("R6 writing one clears edge bit", 5'h04, 32'h08);
      tick();
      // R5 falling edge on source 6
      wreg(5'h10, 32'h60);
      wreg(5'h0C, 32'hFFFF_FFBF);
      src = 32'h48;
      ticks(4);
      rchk("R5 rising ignored for falling polarity", 5'h04, 32'h08);
      tick();
      src = 32'h08;
      ticks(4);
      rchk("R5 falling edge latched", 5'h04, 32'h48);
      tick();
      // R8 clear and new edge in the same cycle
      src = 32'h28;
      ticks(2);
      wreg(5'h04, 32'h20);
      rchk("R8 new edge wins over clear", 5'h04, 32'h68);
      tick();
      wreg(5'h04, 32'h60);
      rchk("R6 clearing two edge bits", 5'h04, 32'h08);
      tick();
      // R10 mixed routing, R9 enable
      wreg(5'h00, 32'h8);
      chk("R10 output still old right after enable", {31'b0, nirq}, 32'h0);
      tick();
      chk("R10 normal output for source 3", {31'b0, nirq}, 32'h1);
      chk("R10 fast output quiet for source 3", {31'b0, firq}, 32'h0);
      wreg(5'h14, 32'h8);
      tick();
      chk("R10 source 3 moved to fast output", {31'b0, firq}, 32'h1);
      chk("R10 normal output released", {31'b0, nirq}, 32'h0);
      wreg(5'h00, 32'h0);
      tick();
      chk("R9 disabled source drives nothing", {30'b0, nirq, firq}, 32'h0);
      rchk("R9 masked cleared by enable", 5'h08, 32'h0);
      tick();
      rchk("R9 raw unaffected by enable", 5'h04, 32'h08);
      tick();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule